// File: doc/BRIEF.md
# Reversible Multi-Input Signature Register

This block is a K-bit parallel-input signature register that compacts one data word per accepted cycle. It has two directions. The forward step folds a word into the state through a feedback polynomial chosen by parameter. The reverse step undoes one forward step exactly, using the reciprocal form of the same polynomial. If a word stream is compacted forward from a seed, and the same stream is then fed in reverse order with the reverse step, the register lands back on the seed. A transparent memory self-test can use this to confirm that contents came back intact without a separate signature-prediction pass.

The polynomial is the parameter `POLY`, K+1 bits wide. Bit j is the coefficient of X^j, and bits 0 and K must both be 1 so that the inverse exists. A wrong value stops elaboration. Each cycle, a small decoder picks one operation: HOLD, LOAD, FWD or REV. The state register then takes the result of that operation.

The decoder has four named operations, and each picks where the next state comes from. LOAD takes the seed and wins over everything else. When LOAD is not selected and a word is valid, FWD or REV follows the direction select. Otherwise the operation is HOLD. Any operation can follow any other from one cycle to the next.

Top module: `rev_misr`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes all zeros, and `sig` shows zero from the following cycle.
- R2: When `seed_load` is high at an edge, `sig` equals `seed` after that edge.
- R3: A forward step is taken when `din_valid` is high, `reverse` is 0 and `seed_load` is 0. In that step the new top bit `sig[K-1]` equals `din[K-1]` XOR the parity of (`POLY[K-1:0]` AND the old `sig`). Bit j of `POLY` weights old state bit j.
- R4: In a forward step, each new bit i < K-1 equals `din[i]` XOR old `sig[i+1]`. The register shifts from the high index toward the low index.
- R5: A reverse step is taken when `din_valid` is high, `reverse` is 1 and `seed_load` is 0. In that step each new bit i ≥ 1 equals old `sig[i-1]` XOR `din[i-1]`.
- R6: In a reverse step, the new bit 0 equals old `sig[K-1]` XOR `din[K-1]` XOR the parity of (`POLY[K-1:1]` AND the new bits K-1..1).
- R7: Start from seed S and compact words D0..Dm forward. Then feed Dm..D0 in reverse. The state ends equal to S for every K and polynomial.
- R8: When `din_valid` and `seed_load` are both low, `sig` keeps its value, whatever `din` and `reverse` are. A change of `reverse` therefore acts only on the next valid word.
- R9: When `seed_load` and `din_valid` are high in the same cycle, the seed is loaded and the word is discarded.
- R10: A forward step followed at once by a reverse step with the same word restores the state from before the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed` into the state |
| seed | input | K | Seed value |
| din | input | K | Data word to compact |
| din_valid | input | 1 | Word on `din` is accepted this cycle |
| reverse | input | 1 | 0 = forward step, 1 = reverse step |
| sig | output | K | Current state (signature) |

## Verification
The bench builds three copies of the block side by side. K=4 uses X^4+X+1, K=8 uses X^8+X^4+X^3+X^2+1, and K=16 uses X^16+X^12+X^3+X+1. All three get the same stimulus, cut down to their own width. The smallest width lets short streams wrap through many states. The wider ones use sparse and dense tap sets, so a tap wrongly mapped to its reciprocal position or an off-by-one in the shift shows up in at least one copy. Random streams of forty words are run forward and then backward, and each copy must recover its seed exactly.

// File: rtl/rev_misr_pkg.sv
package rev_misr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_FWD  = 2'd2,
        OP_REV  = 2'd3
    } misr_op_e;

endpackage

// File: rtl/rev_misr_fwd_step.sv
module rev_misr_fwd_step #(
    parameter int unsigned K = 8,
    parameter logic [K-1:0] TAPS = 8'h1D
) (
    input  logic [K-1:0] cur,
    input  logic [K-1:0] word,
    output logic [K-1:0] nxt
);

    logic feedback;

    always_comb begin
        feedback = word[K-1] ^ (^(TAPS & cur));
    end

    assign nxt = {feedback, word[K-2:0] ^ cur[K-1:1]};

endmodule

// File: rtl/rev_misr_rev_step.sv
module rev_misr_rev_step #(
    parameter int unsigned K = 8,
    parameter logic [K-1:0] TAPS = 8'h1D
) (
    input  logic [K-1:0] cur,
    input  logic [K-1:0] word,
    output logic [K-1:0] prv
);

    logic [K-2:0] upper;
    logic         low_bit;

    always_comb begin
        upper   = cur[K-2:0] ^ word[K-2:0];
        low_bit = cur[K-1] ^ word[K-1] ^ (^(TAPS[K-1:1] & upper));
    end

    assign prv = {upper, low_bit};

endmodule

// File: rtl/rev_misr_op_decode.sv
module rev_misr_op_decode
    import rev_misr_pkg::*;
(
    input  logic     seed_load,
    input  logic     din_valid,
    input  logic     reverse,
    output misr_op_e op
);

    always_comb begin
        if (seed_load) begin
            op = OP_LOAD;
        end else if (din_valid) begin
            op = reverse ? OP_REV : OP_FWD;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/rev_misr.sv
module rev_misr
    import rev_misr_pkg::*;
#(
    parameter int unsigned K = 8,
    parameter logic [K:0]  POLY = 9'h11D
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_load,
    input  logic [K-1:0] seed,
    input  logic [K-1:0] din,
    input  logic         din_valid,
    input  logic         reverse,
    output logic [K-1:0] sig
);

    localparam logic [K-1:0] TAPS = POLY[K-1:0];

    generate
        if (K < 2) begin : g_bad_width
            $error("rev_misr: K must be at least 2");
        end
        if (POLY[0] != 1'b1 || POLY[K] != 1'b1) begin : g_bad_poly
            $error("rev_misr: lowest and highest POLY coefficients must be 1");
        end
    endgenerate

    misr_op_e     op;
    logic [K-1:0] state_q;
    logic [K-1:0] state_d;
    logic [K-1:0] fwd_val;
    logic [K-1:0] rev_val;

    rev_misr_op_decode u_dec (
        .seed_load (seed_load),
        .din_valid (din_valid),
        .reverse   (reverse),
        .op        (op)
    );

    rev_misr_fwd_step #(.K(K), .TAPS(TAPS)) u_fwd (
        .cur  (state_q),
        .word (din),
        .nxt  (fwd_val)
    );

    rev_misr_rev_step #(.K(K), .TAPS(TAPS)) u_rev (
        .cur  (state_q),
        .word (din),
        .prv  (rev_val)
    );

    always_comb begin
        unique case (op)
            OP_LOAD: state_d = seed;
            OP_FWD:  state_d = fwd_val;
            OP_REV:  state_d = rev_val;
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        sig = state_q;
    end

endmodule

// File: rtl/rev_misr_chk.sv
module rev_misr_chk #(
    parameter int unsigned K = 8,
    parameter logic [K:0]  POLY = 9'h11D
) (
    input logic         clk,
    input logic         rst,
    input logic         seed_load,
    input logic [K-1:0] seed,
    input logic [K-1:0] din,
    input logic         din_valid,
    input logic         reverse,
    input logic [K-1:0] sig
);

    logic was_rst = 1'b0;

    always_ff @(posedge clk) begin
        was_rst <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (was_rst) begin
            a_r1_reset_zero: assert (sig == '0);
        end
    end

    a_r2_seed_loaded: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> sig == $past(seed));

    a_r4_fwd_shift: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && din_valid && !reverse)
        |=> sig[K-2:0] == ($past(din[K-2:0]) ^ $past(sig[K-1:1])));

    a_r5_rev_shift: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && din_valid && reverse)
        |=> sig[K-1:1] == ($past(sig[K-2:0]) ^ $past(din[K-2:0])));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !din_valid) |=> $stable(sig));

    a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
        (seed_load && din_valid) |=> sig == $past(seed));

    logic unused_ok;
    assign unused_ok = ^POLY;

endmodule

bind rev_misr rev_misr_chk #(.K(K), .POLY(POLY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seed_load (seed_load),
    .seed      (seed),
    .din       (din),
    .din_valid (din_valid),
    .reverse   (reverse),
    .sig       (sig)
);

// File: tb/rev_misr_tb.sv
`timescale 1ns/1ps
module rev_misr_tb;

    localparam logic [4:0]  P4  = 5'h13;
    localparam logic [8:0]  P8  = 9'h11D;
    localparam logic [16:0] P16 = 17'h1100B;
    localparam int NW = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [15:0] seed = '0;
    logic [15:0] din = '0;
    logic        din_valid = 1'b0;
    logic        reverse = 1'b0;
    logic [3:0]  sig4;
    logic [7:0]  sig8;
    logic [15:0] sig16;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] e4, e8, e16;
    logic [15:0] words [NW];

    always #5 clk = ~clk;

    rev_misr #(.K(4), .POLY(P4)) u_dut_w4 (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed(seed[3:0]),
        .din(din[3:0]), .din_valid(din_valid), .reverse(reverse), .sig(sig4));

    rev_misr #(.K(8), .POLY(P8)) u_dut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed(seed[7:0]),
        .din(din[7:0]), .din_valid(din_valid), .reverse(reverse), .sig(sig8));

    rev_misr #(.K(16), .POLY(P16)) u_dut_w16 (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed(seed),
        .din(din), .din_valid(din_valid), .reverse(reverse), .sig(sig16));

    function automatic logic [15:0] mask(input int k, input logic [15:0] v);
        return v & ((16'h1 << k) - 16'h1) | ((k == 16) ? v : 16'h0);
    endfunction

    // Forward step per R3/R4
    function automatic logic [15:0] mfwd(input int k, input logic [16:0] p,
                                         input logic [15:0] s, input logic [15:0] d);
        logic [15:0] n = '0;
        logic par = 1'b0;
        for (int j = 0; j < k; j++) par ^= p[j] & s[j];
        for (int i = 0; i < k - 1; i++) n[i] = d[i] ^ s[i+1];
        n[k-1] = d[k-1] ^ par;
        return n;
    endfunction

    // Reverse step per R5/R6
    function automatic logic [15:0] mrev(input int k, input logic [16:0] p,
                                         input logic [15:0] s, input logic [15:0] d);
        logic [15:0] n = '0;
        logic par;
        for (int i = 1; i < k; i++) n[i] = s[i-1] ^ d[i-1];
        par = s[k-1] ^ d[k-1];
        for (int j = 1; j < k; j++) par ^= p[j] & n[j];
        n[0] = par;
        return n;
    endfunction

    task automatic check1(input string tag, input int k,
                          input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s K=%0d actual=%h expected=%h", tag, k, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check1(tag, 4,  {12'h0, sig4}, mask(4, e4));
        check1(tag, 8,  {8'h0, sig8},  mask(8, e8));
        check1(tag, 16, sig16,         e16);
    endtask

    // one cycle: inputs set at negedge, outputs sampled at next negedge
    task automatic cyc(input logic ld, input logic [15:0] sd, input logic v,
                       input logic rv, input logic [15:0] d);
        seed_load = ld; seed = sd; din_valid = v; reverse = rv; din = d;
        @(negedge clk);
        if (ld) begin
            e4 = mask(4, sd); e8 = mask(8, sd); e16 = sd;
        end else if (v) begin
            if (rv) begin
                e4 = mrev(4, P4, e4, d); e8 = mrev(8, P8, e8, d); e16 = mrev(16, P16, e16, d);
            end else begin
                e4 = mfwd(4, P4, e4, d); e8 = mfwd(8, P8, e8, d); e16 = mfwd(16, P16, e16, d);
            end
        end
        seed_load = 0; din_valid = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        e4 = '0; e8 = '0; e16 = '0;
        check_all("R1 reset");
    endtask

    task automatic t_seed();
        cyc(1, 16'hA5C3, 0, 0, 16'h0);
        check_all("R2 seed");
    endtask

    task automatic t_fwd_steps();
        cyc(1, 16'h8001, 0, 0, 0);
        cyc(0, 0, 1, 0, 16'h0000);
        check_all("R3 R4 fwd zero word");
        cyc(0, 0, 1, 0, 16'hFFFF);
        check_all("R3 R4 fwd ones word");
        cyc(0, 0, 1, 0, 16'h5A3C);
        check_all("R3 R4 fwd mixed");
    endtask

    task automatic t_rev_steps();
        cyc(1, 16'h1234, 0, 0, 0);
        cyc(0, 0, 1, 1, 16'h0F0F);
        check_all("R5 R6 rev step");
        cyc(0, 0, 1, 1, 16'hC001);
        check_all("R5 R6 rev step 2");
    endtask

    task automatic t_pair();
        logic [15:0] b4, b8, b16;
        cyc(1, 16'h6B2D, 0, 0, 0);
        b4 = e4; b8 = e8; b16 = e16;
        cyc(0, 0, 1, 0, 16'h9E71);
        cyc(0, 0, 1, 1, 16'h9E71);
        check1("R10 fwd-rev pair", 4,  {12'h0, sig4}, b4);
        check1("R10 fwd-rev pair", 8,  {8'h0, sig8},  b8);
        check1("R10 fwd-rev pair", 16, sig16,         b16);
    endtask

    task automatic t_hold();
        cyc(1, 16'h3C5A, 0, 0, 0);
        cyc(0, 0, 1, 0, 16'h1111);
        cyc(0, 0, 0, 1, 16'hFFFF);
        check_all("R8 hold reverse high");
        cyc(0, 0, 0, 0, 16'hBEEF);
        check_all("R8 hold reverse low");
        cyc(0, 0, 1, 1, 16'h2222);
        check_all("R8 mode on next valid word");
    endtask

    task automatic t_priority();
        cyc(1, 16'h0000, 0, 0, 0);
        cyc(1, 16'h7E81, 1, 0, 16'hFFFF);
        check_all("R9 load beats fwd");
        cyc(1, 16'h0102, 1, 1, 16'hAAAA);
        check_all("R9 load beats rev");
    endtask

    task automatic t_roundtrip(input logic [15:0] s0);
        cyc(1, s0, 0, 0, 0);
        for (int i = 0; i < NW; i++) words[i] = 16'($urandom);
        for (int i = 0; i < NW; i++) cyc(0, 0, 1, 0, words[i]);
        check_all("R7 forward signature");
        for (int i = NW - 1; i >= 0; i--) cyc(0, 0, 1, 1, words[i]);
        check1("R7 seed recovered", 4,  {12'h0, sig4}, mask(4, s0));
        check1("R7 seed recovered", 8,  {8'h0, sig8},  mask(8, s0));
        check1("R7 seed recovered", 16, sig16,         s0);
    endtask

    initial begin
        e4 = '0; e8 = '0; e16 = '0;
        @(negedge clk);
        t_reset();
        t_seed();
        t_fwd_steps();
        t_rev_steps();
        t_pair();
        t_hold();
        t_priority();
        t_roundtrip(16'hD00D);
        t_roundtrip(16'h0000);
        t_roundtrip(16'hFFFF);
        t_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule